// File: doc/BRIEF.md
# Level-2 Cache Configuration Register Stub

This block gives software the configuration register window it expects from a second-level cache controller. No cache sits behind it. It decodes a 4 KiB byte-offset space and keeps the following registers so that boot and driver code can program them and read them back:

- the enable bit;
- an auxiliary control word;
- two latency words, one for tags and one for data;
- a pair of address-filter bounds.

It also returns a fixed identification word. A cache-type word is built at read time from a base parameter and the way-size bits in the auxiliary control word.

Cache maintenance operations come in through a fixed address window and three single offsets. The block absorbs them without error. An access to any other unlisted offset reads zero, changes nothing, and raises a one-cycle error strobe so that a test environment can count stray accesses.

The bus port is a single-cycle select/write interface:

- A write takes effect on the clock edge where select and write are both high.
- The read word for any selected access is registered and appears on the following cycle.
- When select is low, the read word holds its last value.

Top module: `l2cfg_regs`

## Requirements
- R1: Offset 0x000 always reads 0x410000C8 (parameter default), and writes to it change nothing.
- R2: A write to offset 0x100 stores only write-data bit 0 as the enable flag. A read of 0x100 returns that flag in bit 0 and zero in bits 31:1.
- R3: Offsets 0x104 (auxiliary control), 0x108 (tag latency) and 0x10C (data latency) each store and return a full 32-bit word.
- R4: Offsets 0xC00 (filter low bound) and 0xC04 (filter high bound) each store and return a full 32-bit word.
- R5: While reset is asserted, the read word and the error strobe are zero. After reset, auxiliary control reads 0x02020000 and every other writable register reads zero.
- R6: Any access to an offset from 0x730 through 0x7FF inclusive reads zero, changes no register, and raises no error. The neighbours 0x72C and 0x800 are not in this window.
- R7: Accesses to offsets 0xF40, 0xF60 and 0xF80 read zero, change no register, and raise no error.
- R8: Offset 0x004 reads the base parameter (default 0x1C100100) ORed with a 5-bit field F placed at bit 18 and again at bit 6. F[4:2] is auxiliary control bits 19:17, F[1] is 0, and F[0] is auxiliary control bit 16.
- R9: An access to any other offset reads zero and changes no register. The error output is high for exactly the cycle after that access and low after every cycle with no such access.
- R10: The read word of an access appears one cycle after select. For a write, it shows the register content from before the write. With select low, the read word keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Access strobe for this cycle |
| wr | input | 1 | Access is a write when high |
| offset | input | 12 | Byte offset inside the register window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read word of the last access |
| err | output | 1 | One-cycle strobe for an access to an unlisted offset |

## Verification
The storing registers are tested with two kinds of pattern:

- **Alternating-bit patterns and all-ones words.** These show whether every bit is really kept, and whether the control register drops bits 31:1.
- **Back-to-back write-then-read pairs.** These show the pre-write read value apart from the post-write value.

The cache-type word is read under several auxiliary values. These values set the way-size bits to different combinations, and they also set bits outside those positions. This separates correct field placement from leakage of neighbouring bits and from a missing zero bit in the field.

Writes go to the quiet window at both edges and in the middle, to each maintenance offset, and to the offsets just outside the window. The stored registers are then read back. This shows whether absorbed accesses, error-raising accesses and real register writes are kept apart.

// File: rtl/l2cfg_pkg.sv
package l2cfg_pkg;
    localparam int unsigned OFS_W  = 12;
    localparam int unsigned WORD_W = 32;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [WORD_W-1:0] word_t;

    // Offsets whose position software relies on
    localparam ofs_t OFS_ID     = 12'h000;
    localparam ofs_t OFS_CTYPE  = 12'h004;
    localparam ofs_t OFS_CTRL   = 12'h100;
    localparam ofs_t OFS_AUX    = 12'h104;
    localparam ofs_t OFS_TAGL   = 12'h108;
    localparam ofs_t OFS_DATAL  = 12'h10C;
    localparam ofs_t OFS_FLO    = 12'hC00;
    localparam ofs_t OFS_FHI    = 12'hC04;
    localparam ofs_t QUIET_LO   = 12'h730;
    localparam ofs_t QUIET_HI   = 12'h7FF;

    // Way-size bits inside the auxiliary control word
    localparam int unsigned WAY_LSB = 16;
    localparam int unsigned WAY_W   = 4;

    typedef enum logic [3:0] {
        K_ID, K_CTYPE, K_CTRL, K_AUX, K_TAGL, K_DATAL,
        K_FLO, K_FHI, K_QUIET, K_BAD
    } kind_e;

    typedef struct packed {
        logic  en;
        word_t aux;
        word_t tagl;
        word_t datal;
        word_t flo;
        word_t fhi;
    } cfg_t;

    typedef struct packed {
        word_t rdata;
        logic  err;
    } resp_t;
endpackage

// File: rtl/l2cfg_decode.sv
module l2cfg_decode
    import l2cfg_pkg::*;
#(
    parameter int unsigned N_MAINT = 3,
    parameter logic [N_MAINT*OFS_W-1:0] MAINT_OFS = {12'hF80, 12'hF60, 12'hF40}
) (
    input  ofs_t  ofs,
    output kind_e kind
);
    logic [N_MAINT-1:0] maint_hit;
    logic               in_quiet;

    for (genvar g = 0; g < N_MAINT; g++) begin : g_maint
        assign maint_hit[g] = (ofs == MAINT_OFS[g*OFS_W +: OFS_W]);
    end

    assign in_quiet = (ofs >= QUIET_LO) && (ofs <= QUIET_HI);

    always_comb begin
        kind = K_BAD;
        if (in_quiet || (|maint_hit)) begin
            kind = K_QUIET;
        end else begin
            case (ofs)
                OFS_ID:    kind = K_ID;
                OFS_CTYPE: kind = K_CTYPE;
                OFS_CTRL:  kind = K_CTRL;
                OFS_AUX:   kind = K_AUX;
                OFS_TAGL:  kind = K_TAGL;
                OFS_DATAL: kind = K_DATAL;
                OFS_FLO:   kind = K_FLO;
                OFS_FHI:   kind = K_FHI;
                default:   kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/l2cfg_store.sv
module l2cfg_store
    import l2cfg_pkg::*;
#(
    parameter word_t AUX_RESET = 32'h0202_0000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  kind_e kind,
    input  word_t wdata,
    output cfg_t  cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (kind)
                K_CTRL:  cfg_d.en    = wdata[0];
                K_AUX:   cfg_d.aux   = wdata;
                K_TAGL:  cfg_d.tagl  = wdata;
                K_DATAL: cfg_d.datal = wdata;
                K_FLO:   cfg_d.flo   = wdata;
                K_FHI:   cfg_d.fhi   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{en: 1'b0, aux: AUX_RESET, tagl: '0, datal: '0, flo: '0, fhi: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/l2cfg_typeword.sv
module l2cfg_typeword
    import l2cfg_pkg::*;
#(
    parameter word_t BASE = 32'h1C10_0100
) (
    input  logic [WAY_W-1:0] way_bits,
    output word_t            type_word
);
    localparam int unsigned FIELD_W = 5;
    localparam int unsigned POS_HI  = 18;
    localparam int unsigned POS_LO  = 6;

    logic [FIELD_W-1:0] field;

    assign field     = {way_bits[WAY_W-1:1], 1'b0, way_bits[0]};
    assign type_word = BASE | (word_t'(field) << POS_HI) | (word_t'(field) << POS_LO);
endmodule

// File: rtl/l2cfg_regs.sv
module l2cfg_regs
    import l2cfg_pkg::*;
#(
    parameter logic [31:0] ID_WORD    = 32'h4100_00C8,
    parameter logic [31:0] TYPE_BASE  = 32'h1C10_0100,
    parameter logic [31:0] AUX_RESET  = 32'h0202_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic        wr,
    input  logic [11:0] offset,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        err
);
    kind_e kind;
    cfg_t  cfg;
    word_t type_word;
    resp_t resp_d, resp_q;

    l2cfg_decode u_dec (
        .ofs  (offset),
        .kind (kind)
    );

    l2cfg_store #(.AUX_RESET(AUX_RESET)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sel && wr),
        .kind  (kind),
        .wdata (wdata),
        .cfg   (cfg)
    );

    l2cfg_typeword #(.BASE(TYPE_BASE)) u_type (
        .way_bits  (cfg.aux[WAY_LSB +: WAY_W]),
        .type_word (type_word)
    );

    always_comb begin
        resp_d     = resp_q;
        resp_d.err = 1'b0;
        if (sel) begin
            resp_d.err = (kind == K_BAD);
            case (kind)
                K_ID:    resp_d.rdata = ID_WORD;
                K_CTYPE: resp_d.rdata = type_word;
                K_CTRL:  resp_d.rdata = {{(WORD_W-1){1'b0}}, cfg.en};
                K_AUX:   resp_d.rdata = cfg.aux;
                K_TAGL:  resp_d.rdata = cfg.tagl;
                K_DATAL: resp_d.rdata = cfg.datal;
                K_FLO:   resp_d.rdata = cfg.flo;
                K_FHI:   resp_d.rdata = cfg.fhi;
                default: resp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rdata = resp_q.rdata;
    assign err   = resp_q.err;
endmodule

// File: rtl/l2cfg_regs_chk.sv
module l2cfg_regs_chk #(
    parameter logic [31:0] ID_WORD = 32'h4100_00C8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic [11:0] offset,
    input logic [31:0] rdata,
    input logic        err
);
    // R1: identification word
    a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && offset == 12'h000) |-> (rdata == ID_WORD && !err));

    // R2: control reads only bit 0
    a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && offset == 12'h100) |-> (rdata[31:1] == 31'd0));

    // R6: quiet window
    a_r6_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && offset >= 12'h730 && offset <= 12'h7FF) |-> (rdata == 32'd0 && !err));

    // R7: maintenance offsets
    a_r7_maint_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel && (offset == 12'hF40 || offset == 12'hF60 || offset == 12'hF80))
        |-> (rdata == 32'd0 && !err));

    // R9: error only after an access, with zero data
    a_r9_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(sel) && rdata == 32'd0));

    // R10: read word holds when idle
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> ($stable(rdata) && !err));
endmodule

bind l2cfg_regs l2cfg_regs_chk #(.ID_WORD(ID_WORD)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .offset (offset),
    .rdata  (rdata),
    .err    (err)
);

// File: tb/sim_l2cfg_regs.sv
module sim_l2cfg_regs;
    typedef struct {
        logic [31:0] rd;
        logic        er;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [11:0] offset = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t q[$];
    logic [31:0] last_rd = '0;

    // bench model of stored state
    logic        m_en = 1'b0;
    logic [31:0] m_aux = 32'h0202_0000;
    logic [31:0] m_tagl = '0, m_datal = '0, m_flo = '0, m_fhi = '0;

    always #2 clk = ~clk;

    l2cfg_regs u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .wr     (wr),
        .offset (offset),
        .wdata  (wdata),
        .rdata  (rdata),
        .err    (err)
    );

    function automatic logic [31:0] exp_ctype(input logic [31:0] aux);
        logic [4:0] f;
        f = {aux[19:17], 1'b0, aux[16]};
        return 32'h1C10_0100 | ({27'd0, f} << 18) | ({27'd0, f} << 6);
    endfunction

    function automatic bit is_quiet(input logic [11:0] o);
        return (o >= 12'h730 && o <= 12'h7FF) || o == 12'hF40 || o == 12'hF60 || o == 12'hF80;
    endfunction

    task automatic access(input bit w, input logic [11:0] o, input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        e.tag = tag;
        e.er  = 1'b0;
        case (o)
            12'h000: e.rd = 32'h4100_00C8;
            12'h004: e.rd = exp_ctype(m_aux);
            12'h100: e.rd = {31'd0, m_en};
            12'h104: e.rd = m_aux;
            12'h108: e.rd = m_tagl;
            12'h10C: e.rd = m_datal;
            12'hC00: e.rd = m_flo;
            12'hC04: e.rd = m_fhi;
            default: begin
                e.rd = '0;
                e.er = !is_quiet(o);
            end
        endcase
        q.push_back(e);
        sel = 1'b1; wr = w; offset = o; wdata = d;
        if (w) begin
            case (o)
                12'h100: m_en    = d[0];
                12'h104: m_aux   = d;
                12'h108: m_tagl  = d;
                12'h10C: m_datal = d;
                12'hC00: m_flo   = d;
                12'hC04: m_fhi   = d;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sel = 1'b0; wr = 1'b0;
        end
    endtask

    task automatic read_all(input string tag);
        access(0, 12'h100, 0, tag);
        access(0, 12'h104, 0, tag);
        access(0, 12'h108, 0, tag);
        access(0, 12'h10C, 0, tag);
        access(0, 12'hC00, 0, tag);
        access(0, 12'hC04, 0, tag);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rdata !== e.rd || err !== e.er) begin
                    failures++;
                    $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                             e.tag, rdata, err, e.rd, e.er);
                end
                last_rd = e.rd;
            end else if (err !== 1'b0) begin
                checks++;
                failures++;
                $display("FAIL R9 idle cycle: err=%b expected 0", err);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: done=0 expected 1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rdata !== 32'd0 || err !== 1'b0) begin
            failures++;
            $display("FAIL R5 in reset: rdata=%h err=%b expected 0 0", rdata, err);
        end
        rst_n = 1'b1;
        idle(1);

        // R5 reset contents, R1 id, R8 default type word
        access(0, 12'h000, 0, "R1 id read");
        access(0, 12'h004, 0, "R8 type word after reset");
        read_all("R5 reset value");

        // R2 control enable bit only
        access(1, 12'h100, 32'hFFFF_FFFE, "R2 ctrl write upper bits");
        access(0, 12'h100, 0, "R2 ctrl only bit0");
        access(1, 12'h100, 32'hFFFF_FFFF, "R2 ctrl write all ones");
        access(0, 12'h100, 0, "R2 ctrl reads 1");

        // R3 / R4 full words, R10 write returns old then new
        access(1, 12'h104, 32'hA5A5_5A5A, "R10 write shows old aux");
        access(0, 12'h104, 0, "R3 aux readback");
        access(1, 12'h108, 32'hFFFF_FFFF, "R3 tag latency write");
        access(1, 12'h10C, 32'h5555_AAAA, "R3 data latency write");
        access(0, 12'h108, 0, "R3 tag latency readback");
        access(0, 12'h10C, 0, "R3 data latency readback");
        access(1, 12'hC00, 32'h8000_0001, "R4 filter low write");
        access(1, 12'hC04, 32'h7FFF_FFFE, "R4 filter high write");
        access(0, 12'hC00, 0, "R4 filter low readback");
        access(0, 12'hC04, 0, "R4 filter high readback");
        access(1, 12'hC04, 32'h1234_5678, "R10 write shows old filter high");
        access(0, 12'hC04, 0, "R4 filter high rewrite");

        // R8 type word under several way-size patterns
        access(0, 12'h004, 0, "R8 type word aux A5A55A5A");
        access(1, 12'h104, 32'h000F_0000, "R3 aux way bits all set");
        access(0, 12'h004, 0, "R8 type word way bits 1111");
        access(1, 12'h104, 32'hFFF2_FFFF, "R3 aux way bits 0010");
        access(0, 12'h004, 0, "R8 type word way bits 0010");
        access(1, 12'h104, 32'h0005_0000, "R3 aux way bits 0101");
        access(0, 12'h004, 0, "R8 type word way bits 0101");

        // R6 quiet window edges and middle, R7 maintenance offsets
        access(1, 12'h730, 32'hFFFF_FFFF, "R6 window low edge");
        access(1, 12'h7FF, 32'hFFFF_FFFF, "R6 window high edge");
        access(0, 12'h7A4, 0, "R6 window middle read");
        access(1, 12'hF40, 32'hDEAD_BEEF, "R7 maint F40");
        access(1, 12'hF60, 32'hDEAD_BEEF, "R7 maint F60");
        access(0, 12'hF80, 0, "R7 maint F80");
        idle(2);
        read_all("R6 R7 state unchanged");

        // R9 bad offsets, including window neighbours; R1 write ignored
        access(1, 12'h72C, 32'hFFFF_FFFF, "R9 below window");
        idle(1);
        access(1, 12'h800, 32'hFFFF_FFFF, "R9 above window");
        access(1, 12'h008, 32'hFFFF_FFFF, "R9 bad 008");
        access(1, 12'hF44, 32'hFFFF_FFFF, "R9 bad F44");
        access(0, 12'hFFC, 0, "R9 bad FFC read");
        access(1, 12'h000, 32'h0000_0000, "R1 id write");
        access(1, 12'h004, 32'h0000_0000, "R8 type word write ignored");
        access(0, 12'h000, 0, "R1 id after write");
        read_all("R9 state unchanged");
        access(0, 12'h004, 0, "R8 type word after bad writes");

        // R10 hold while idle
        access(0, 12'h104, 0, "R10 last read");
        idle(3);
        checks++;
        if (rdata !== last_rd) begin
            failures++;
            $display("FAIL R10 idle hold: rdata=%h expected %h", rdata, last_rd);
        end
        idle(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule